// File: doc/BRIEF.md
# Stopwatch with Lap Capture

This block is the timing core of a four-digit stopwatch for a small FPGA board. It accepts four clean, one-cycle button pulses (go, halt, zero and lap), keeps an elapsed time of seconds and hundredths in BCD, and drives a time-multiplexed common-anode seven-segment display. A control state machine decides when time advances, when it may be cleared and which value the display shows.

A divider turns the system clock into a hundredth-of-a-second tick that advances the BCD counter while the watch is running. A lap press freezes a copy of the current time in a separate register and puts that copy on the display while the counter keeps running underneath. A second lap press switches the display back to live time. A second divider sets the refresh rate of the digit scanner, which enables one digit at a time and decodes that digit's value into segment lines.

Top module: `chrono_lap_top`

## Requirements
- R1: After reset the watch is idle and the display shows 00.00.
- R2: After reset, exactly one bit of `dig_en_n` is low at any time. The low bit moves from bit 0 to bit 1, then to bit 2, then to bit 3 and back to bit 0, once every `SCAN_DIV` clock cycles. Bit 3 selects the seconds-tens digit, bit 2 the seconds units, bit 1 the hundredths tens and bit 0 the hundredths units.
- R3: `seg_n` carries the active-low segment pattern of the enabled digit, with bit 0 = a, bit 1 = b and so on up to bit 6 = g. The lit sets are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all seven, 9 abcdfg.
- R4: A go pulse in the idle or paused state starts counting. The time then advances by one hundredth for every `TICK_DIV` clock cycles spent counting, and the tick divider restarts from zero at each start.
- R5: A halt pulse while running stops counting and the shown time holds. A later go pulse resumes counting from the held value.
- R6: Each digit carries in BCD: hundredths units 9 to 0 carries into hundredths tens, hundredths tens 9 to 0 carries into seconds units, seconds units 9 to 0 carries into seconds tens, and 59.99 rolls over to 00.00.
- R7: A zero pulse clears the time to 00.00 and returns the watch to idle, but only in the idle or paused state. While counting, a zero pulse is ignored.
- R8: A lap pulse while running captures the current time and shows it frozen, while the counter keeps counting. A second lap pulse shows live time again, with no counts lost.
- R9: A halt pulse while a lap is shown stops counting and shows the live time.
- R10: A lap or halt pulse while idle, a lap pulse while paused and a go pulse while counting are all ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_go | input | 1 | One-cycle start/resume pulse |
| btn_halt | input | 1 | One-cycle stop pulse |
| btn_zero | input | 1 | One-cycle clear pulse |
| btn_lap | input | 1 | One-cycle lap capture/release pulse |
| seg_n | output | 7 | Active-low segment lines a (bit 0) to g (bit 6) |
| dig_en_n | output | 4 | Active-low digit enables, bit 3 leftmost |

## Verification
The bench builds the block with `TICK_DIV` = 4 and `SCAN_DIV` = 2. With these values one hundredth lasts four cycles and a full display scan takes eight, so a complete run up to 59.99 and the rollover past it fit in about 24,000 cycles. The bench can also read all four digits off the segment lines in a fixed sixteen-cycle window while a lap value is frozen. The run lengths are chosen so that each one ends between two ticks, which makes every expected count exact.

// File: rtl/chrono_pkg.sv
package chrono_pkg;

  localparam int unsigned NUM_DIGITS = 4;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned TIME_W     = NUM_DIGITS * DIGIT_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2,
    ST_LAPV  = 2'd3
  } sw_state_e;

  // Lit segments, active high, bit 0 = a ... bit 6 = g.
  function automatic logic [6:0] seg_lit(input logic [DIGIT_W-1:0] d);
    logic [6:0] s;
    case (d)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/chrono_divider.sv
module chrono_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign tick   = en && (cnt_q == LAST);
  assign cnt_en = clr || en;

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/chrono_bcd_digit.sv
module chrono_bcd_digit #(
  parameter logic [3:0] LIMIT = 4'd9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       inc,
  output logic [3:0] value
);
  logic [3:0] val_d;
  logic       upd;

  assign upd = clr || inc;

  always_comb begin
    if (clr)                 val_d = '0;
    else if (value == LIMIT) val_d = '0;
    else                     val_d = value + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (upd) value <= val_d;
  end
endmodule

// File: rtl/chrono_time_counter.sv
module chrono_time_counter
  import chrono_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                inc,
  input  logic                                clr,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0]  digs
);
  logic [NUM_DIGITS-1:0] cy;

  assign cy[0] = inc;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    // The most significant digit counts seconds tens and stops at 5.
    localparam logic [3:0] LIM = (i == NUM_DIGITS - 1) ? 4'd5 : 4'd9;

    chrono_bcd_digit #(.LIMIT(LIM)) i_digit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (cy[i]),
      .value (digs[i])
    );

    if (i < NUM_DIGITS - 1) begin : g_carry
      assign cy[i+1] = cy[i] && (digs[i] == LIM);
    end
  end
endmodule

// File: rtl/chrono_ctrl.sv
module chrono_ctrl
  import chrono_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      halt,
  input  logic      zero,
  input  logic      lap,
  output sw_state_e state,
  output logic      count_en,
  output logic      clear,
  output logic      capture,
  output logic      show_lap
);
  sw_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE: begin
        if (go) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (halt)     state_d = ST_PAUSE;
        else if (lap) state_d = ST_LAPV;
      end
      ST_LAPV: begin
        if (halt)     state_d = ST_PAUSE;
        else if (lap) state_d = ST_RUN;
      end
      ST_PAUSE: begin
        if (zero)    state_d = ST_IDLE;
        else if (go) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign count_en = (state == ST_RUN) || (state == ST_LAPV);
  assign clear    = zero && ((state == ST_IDLE) || (state == ST_PAUSE));
  assign capture  = lap && !halt && (state == ST_RUN);
  assign show_lap = (state == ST_LAPV);
endmodule

// File: rtl/chrono_scan.sv
module chrono_scan
  import chrono_pkg::*;
#(
  parameter int unsigned SCAN_DIV = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digs,
  output logic [6:0]                         seg_n,
  output logic [NUM_DIGITS-1:0]              dig_en_n
);
  logic                  refresh;
  logic [NUM_DIGITS-1:0] sel_q;
  logic [NUM_DIGITS-1:0] sel_d;
  logic [DIGIT_W-1:0]    cur;

  chrono_divider #(.DIV(SCAN_DIV)) i_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .clr   (1'b0),
    .tick  (refresh)
  );

  assign sel_d = {sel_q[NUM_DIGITS-2:0], sel_q[NUM_DIGITS-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= NUM_DIGITS'(1);
    else if (refresh) sel_q <= sel_d;
  end

  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (sel_q[i]) cur = digs[i];
    end
  end

  assign seg_n    = ~seg_lit(cur);
  assign dig_en_n = ~sel_q;
endmodule

// File: rtl/chrono_lap_top.sv
module chrono_lap_top
  import chrono_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1_250_000,
  parameter int unsigned SCAN_DIV = 125_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_go,
  input  logic       btn_halt,
  input  logic       btn_zero,
  input  logic       btn_lap,
  output logic [6:0] seg_n,
  output logic [3:0] dig_en_n
);
  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  sw_state_e   state;
  logic        count_en, clear, capture, show_lap, hundredth;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] live_digs;
  logic [TIME_W-1:0] live_val, lap_val, shown_val;

  // Reset asserts at once and leaves after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  chrono_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go       (btn_go),
    .halt     (btn_halt),
    .zero     (btn_zero),
    .lap      (btn_lap),
    .state    (state),
    .count_en (count_en),
    .clear    (clear),
    .capture  (capture),
    .show_lap (show_lap)
  );

  chrono_divider #(.DIV(TICK_DIV)) i_timebase (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (count_en),
    .clr   (!count_en),
    .tick  (hundredth)
  );

  chrono_time_counter i_time (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (hundredth),
    .clr   (clear),
    .digs  (live_digs)
  );

  assign live_val = live_digs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lap_val <= '0;
    else if (!rst_sync_n) lap_val <= '0;
    else if (clear)   lap_val <= '0;
    else if (capture) lap_val <= live_val;
  end

  assign shown_val = show_lap ? lap_val : live_val;

  chrono_scan #(.SCAN_DIV(SCAN_DIV)) i_scan (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .digs     (shown_val),
    .seg_n    (seg_n),
    .dig_en_n (dig_en_n)
  );
endmodule

// File: rtl/chrono_lap_checker.sv
module chrono_lap_checker
  import chrono_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input sw_state_e             state,
  input logic                  count_en,
  input logic                  clear,
  input logic                  capture,
  input logic                  show_lap,
  input logic [TIME_W-1:0]     live_val,
  input logic [TIME_W-1:0]     lap_val,
  input logic [NUM_DIGITS-1:0] dig_en_n
);
  localparam int unsigned N = NUM_DIGITS;

  p_one_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_en_n) == 1);

  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en_n != $past(dig_en_n)) |->
      (dig_en_n == {$past(dig_en_n[N-2:0]), $past(dig_en_n[N-1])}));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clear) |=> $stable(live_val));

  p_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_val[15:12] <= 4'd5) && (live_val[11:8] <= 4'd9) &&
    (live_val[7:4] <= 4'd9) && (live_val[3:0] <= 4'd9));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((live_val == '0) && (state == ST_IDLE)));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (show_lap && (lap_val == $past(live_val))));

  p_lap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clear) |=> $stable(lap_val));
endmodule

bind chrono_lap_top chrono_lap_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .state    (state),
  .count_en (count_en),
  .clear    (clear),
  .capture  (capture),
  .show_lap (show_lap),
  .live_val (live_val),
  .lap_val  (lap_val),
  .dig_en_n (dig_en_n)
);

// File: tb/test_chrono_lap_top.sv
`timescale 1ns/1ps
module test_chrono_lap_top;
  localparam int TICK = 4;
  localparam int SCAN = 2;
  localparam int B_GO = 0, B_HALT = 1, B_ZERO = 2, B_LAP = 3;

  logic clk, rst_n, btn_go, btn_halt, btn_zero, btn_lap;
  logic [6:0] seg_n;
  logic [3:0] dig_en_n;
  int total = 0, bad = 0;
  bit done = 0;

  chrono_lap_top #(.TICK_DIV(TICK), .SCAN_DIV(SCAN)) i_chrono_lap_top (
    .clk(clk), .rst_n(rst_n), .btn_go(btn_go), .btn_halt(btn_halt),
    .btn_zero(btn_zero), .btn_lap(btn_lap), .seg_n(seg_n), .dig_en_n(dig_en_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int seg2dig(input logic [6:0] s_n);
    case (~s_n)
      7'h3F: return 0;  7'h06: return 1;  7'h5B: return 2;  7'h4F: return 3;
      7'h66: return 4;  7'h6D: return 5;  7'h7D: return 6;  7'h07: return 7;
      7'h7F: return 8;  7'h6F: return 9;
      default: return 15;
    endcase
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic press(input int b);
    btn_go = (b == B_GO); btn_halt = (b == B_HALT);
    btn_zero = (b == B_ZERO); btn_lap = (b == B_LAP);
    @(negedge clk);
    btn_go = 0; btn_halt = 0; btn_zero = 0; btn_lap = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reads the display over exactly 16 cycles.
  task automatic read_disp(output int val, output int scan_ok);
    int d[4];
    bit seen[4];
    logic [3:0] prev;
    bit first;
    first = 1; scan_ok = 1; prev = 4'hF;
    for (int i = 0; i < 4; i++) begin d[i] = 0; seen[i] = 0; end
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if ($countones(~dig_en_n) != 1) scan_ok = 0;
      else begin
        for (int i = 0; i < 4; i++)
          if (!dig_en_n[i]) begin d[i] = seg2dig(seg_n); seen[i] = 1; end
        if (!first && dig_en_n != prev && dig_en_n != {prev[2:0], prev[3]}) scan_ok = 0;
        prev = dig_en_n; first = 0;
      end
    end
    for (int i = 0; i < 4; i++) if (!seen[i]) scan_ok = 0;
    if (d[0] > 9 || d[1] > 9 || d[2] > 9 || d[3] > 9) val = -1;
    else val = d[3] * 1000 + d[2] * 100 + d[1] * 10 + d[0];
  endtask

  task automatic expect_disp(input string req, input int exp);
    int v, ok;
    read_disp(v, ok);
    check_int(req, "display (R3 segment codes)", v, exp);
    check_int("R2", "single rotating digit enable", ok, 1);
  endtask

  task automatic t_reset;
    rst_n = 0; btn_go = 0; btn_halt = 0; btn_zero = 0; btn_lap = 0;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(4);
    expect_disp("R1", 0);
  endtask

  task automatic t_start_stop;
    press(B_GO); wait_cyc(4 * 37 + 1); press(B_HALT);   // 150 counting edges
    expect_disp("R4", 37);
  endtask

  task automatic t_pause_resume;
    wait_cyc(100);
    expect_disp("R5", 37);
    press(B_GO); wait_cyc(101); press(B_HALT);          // 102 edges -> 25
    expect_disp("R6", 62);
    press(B_LAP);                                       // lap while paused
    expect_disp("R10", 62);
  endtask

  task automatic t_zero_rules;
    press(B_GO); wait_cyc(20); press(B_ZERO); wait_cyc(21); press(B_HALT); // 43 -> 10
    expect_disp("R7", 72);
    press(B_ZERO);
    expect_disp("R7", 0);
    press(B_LAP); press(B_HALT);                        // both ignored in idle
    expect_disp("R10", 0);
  endtask

  task automatic t_lap;
    press(B_GO); wait_cyc(201); press(B_LAP);           // capture at 50
    expect_disp("R8", 50);
    press(B_LAP);
    wait_cyc(20); press(B_GO); wait_cyc(21);            // go while counting
    press(B_HALT);                                      // 262 edges -> 65
    expect_disp("R8", 65);
  endtask

  task automatic t_lap_halt;
    press(B_GO); wait_cyc(13); press(B_LAP);            // lap at 68
    expect_disp("R8", 68);
    press(B_HALT);                                      // 31 edges -> 72
    expect_disp("R9", 72);
    press(B_ZERO);
    expect_disp("R7", 0);
  endtask

  task automatic t_rollover;
    press(B_GO); wait_cyc(4 * 5999 + 1); press(B_HALT); // 23998 -> 5999
    expect_disp("R6", 5999);
    press(B_GO); wait_cyc(9); press(B_HALT);            // 2 more -> wrap
    expect_disp("R6", 1);
  endtask

  initial begin
    t_reset();
    t_start_stop();
    t_pause_resume();
    t_zero_rules();
    t_lap();
    t_lap_halt();
    t_rollover();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule